// File: doc/BRIEF.md
# Latency Stopwatch Timer

This block is an elapsed-time counter for a USB host or on-the-go controller. A 24-bit count advances once for every 10 µs tick. A prescaler divides the system clock down to produce that tick. Software reaches the block through a command-coded register port. In one 32-bit word it sees a run flag in the top bit and the live count in the low 24 bits.

Software starts a measurement by writing the run flag as 1. This clears the count and the prescaler. A write of 0 halts the count, and the count keeps its value. The timer also halts by itself in two cases. The first is when the count reaches its ceiling. The second is when any interrupt source is active while its matching enable bit is set. That second case freezes the count at the moment of the event, so software can read the latency of the event after the fact.

Top module: `latency_stopwatch`

## Requirements
- R1: A read command (command bit 7 = 0, bits 6:0 = `REG_INDEX`) with `cmd_valid` high returns `{run, zeros, count}` on `rdata` in the same cycle, with run at bit 31 and the count at bits 23:0. Any other command, and any cycle without `cmd_valid`, gives `rdata` = 0.
- R2: A write command (bit 7 = 1) to `REG_INDEX` with `wdata[31]` = 1 sets run, clears the count to 0 and clears the prescaler. This holds whether the timer was running or not.
- R3: A write to `REG_INDEX` with `wdata[31]` = 0 clears run, and the count keeps the value it had.
- R4: When the count is incremented to `MAX_COUNT`, run clears in that same cycle and the count stays at `MAX_COUNT`. It never goes past that value.
- R5: If run is set and any bit of `irq_status` and the same bit of `irq_enable` are both 1, run clears at the next edge. The count is frozen at its value from that moment, and that edge adds no increment.
- R6: Bits 30:24 of `rdata` always read 0. Values written to those bits have no effect.
- R7: An `irq_status` bit whose `irq_enable` bit is 0 does not stop the timer. An enable bit whose status bit is 0 does not stop it either.
- R8: If a start write and an enabled interrupt occur in the same cycle, the start wins. The timer is then running with a count of 0.
- R9: While running, the count rises by one every `CLK_HZ/TICK_HZ` clock cycles. The first increment comes exactly one full divide period after the start edge.
- R10: A write to any register index other than `REG_INDEX` changes neither run nor the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd | input | 8 | Bit 7 = write, bits 6:0 = register index |
| wdata | input | 32 | Write data; bit 31 is the run flag |
| rdata | output | 32 | Read data: run, reserved zeros, count |
| irq_status | input | IRQ_W | Interrupt source status bits |
| irq_enable | input | IRQ_W | Per-source enable bits |

## Verification
The assertions assume three things about the inputs. The command and data inputs hold steady across each clock edge. `MAX_COUNT` is at least 1, so a count of 0 right after a start never equals the ceiling. `irq_status` and `irq_enable` are synchronous to `clk`.

The stimulus meets these assumptions. It changes every input only on the falling edge. It pulses a command for exactly one rising edge. It uses a divide of 10 with a ceiling of 40, so that saturation falls inside a short run. It raises interrupt bits only between two falling edges, which lets the edge on which the freeze happens be known in advance.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef struct packed {
    logic       is_write;
    logic [6:0] index;
  } sw_cmd_t;

  // Clock cycles per count step; never below one.
  function automatic int unsigned tick_divisor(input int unsigned clk_hz,
                                               input int unsigned tick_hz);
    int unsigned d;
    d = clk_hz / tick_hz;
    return (d == 0) ? 1 : d;
  endfunction

  // Bits needed to hold a prescaler phase 0..div-1.
  function automatic int unsigned phase_bits(input int unsigned div);
    return (div > 1) ? $clog2(div) : 1;
  endfunction

endpackage

// File: rtl/sw_cmd_decode.sv
module sw_cmd_decode #(
  parameter logic [6:0] REG_INDEX = 7'h0C
) (
  input  logic        cmd_valid,
  input  logic [7:0]  cmd,
  input  logic        run_bit,
  output logic        start_wr,
  output logic        stop_wr,
  output logic        rd_hit
);
  import sw_pkg::*;

  sw_cmd_t c;
  logic    hit;

  assign c        = sw_cmd_t'(cmd);
  assign hit      = cmd_valid && (c.index == REG_INDEX);
  assign start_wr = hit &&  c.is_write &&  run_bit;
  assign stop_wr  = hit &&  c.is_write && !run_bit;
  assign rd_hit   = hit && !c.is_write;
endmodule

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
  parameter int unsigned DIV = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic enable,
  output logic tick
);
  import sw_pkg::*;

  localparam int unsigned PW = phase_bits(DIV);

  generate
    if (DIV == 1) begin : g_passthru
      assign tick = enable && !clear;
    end else begin : g_divide
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase_q <= '0;
        else if (clear)          phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + 1'b1;
      end
      assign tick = enable && !clear && (phase_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sw_irq_detect.sv
module sw_irq_detect #(
  parameter int unsigned IRQ_W = 8
) (
  input  logic [IRQ_W-1:0] status,
  input  logic [IRQ_W-1:0] enable,
  output logic             irq_hit
);
  logic [IRQ_W-1:0] armed;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_src
    assign armed[i] = status[i] & enable[i];
  end

  assign irq_hit = |armed;
endmodule

// File: rtl/sw_counter_core.sv
module sw_counter_core #(
  parameter int unsigned COUNT_W   = 24,
  parameter int unsigned MAX_COUNT = 24'hFFFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_wr,
  input  logic               stop_wr,
  input  logic               irq_hit,
  input  logic               tick,
  output logic               run,
  output logic [COUNT_W-1:0] count,
  output logic               sat_hit
);
  localparam logic [COUNT_W-1:0] TOP  = COUNT_W'(MAX_COUNT);
  localparam logic [COUNT_W-1:0] LAST = COUNT_W'(MAX_COUNT - 1);

  logic               run_q;
  logic [COUNT_W-1:0] cnt_q;

  assign sat_hit = run_q && tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_wr) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (stop_wr) begin
      run_q <= 1'b0;
    end else if (run_q && irq_hit) begin
      run_q <= 1'b0;
    end else if (run_q && tick && cnt_q != TOP) begin
      cnt_q <= cnt_q + 1'b1;
      if (sat_hit) run_q <= 1'b0;
    end
  end

  assign run   = run_q;
  assign count = cnt_q;
endmodule

// File: rtl/latency_stopwatch.sv
module latency_stopwatch #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned TICK_HZ   = 100_000,
  parameter int unsigned COUNT_W   = 24,
  parameter int unsigned MAX_COUNT = 24'hFFFFFF,
  parameter int unsigned IRQ_W     = 8,
  parameter logic [6:0]  REG_INDEX = 7'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [IRQ_W-1:0] irq_status,
  input  logic [IRQ_W-1:0] irq_enable
);
  import sw_pkg::*;

  localparam int unsigned DIV = tick_divisor(CLK_HZ, TICK_HZ);
  localparam int unsigned RSV = 31 - COUNT_W;

  logic               start_wr;
  logic               stop_wr;
  logic               rd_hit;
  logic               irq_hit;
  logic               tick;
  logic               run;
  logic               sat_hit;
  logic [COUNT_W-1:0] count;

  sw_cmd_decode #(.REG_INDEX(REG_INDEX)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .run_bit   (wdata[31]),
    .start_wr  (start_wr),
    .stop_wr   (stop_wr),
    .rd_hit    (rd_hit)
  );

  sw_prescaler #(.DIV(DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start_wr || !run),
    .enable (run),
    .tick   (tick)
  );

  sw_irq_detect #(.IRQ_W(IRQ_W)) u_irq (
    .status  (irq_status),
    .enable  (irq_enable),
    .irq_hit (irq_hit)
  );

  sw_counter_core #(.COUNT_W(COUNT_W), .MAX_COUNT(MAX_COUNT)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_wr (start_wr),
    .stop_wr  (stop_wr),
    .irq_hit  (irq_hit),
    .tick     (tick),
    .run      (run),
    .count    (count),
    .sat_hit  (sat_hit)
  );

  assign rdata = rd_hit ? {run, {RSV{1'b0}}, count} : 32'd0;
endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
  parameter int unsigned COUNT_W   = 24,
  parameter int unsigned MAX_COUNT = 24'hFFFFFF
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_wr,
  input logic               stop_wr,
  input logic               irq_hit,
  input logic               sat_hit,
  input logic               run,
  input logic [COUNT_W-1:0] count,
  input logic [31:0]        rdata
);
  localparam logic [COUNT_W-1:0] TOP = COUNT_W'(MAX_COUNT);

  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (run && count == '0)); // R2

  AST_SW_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_wr && !start_wr) |=> (!run && $stable(count))); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= TOP); // R4

  AST_SAT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_hit && !start_wr && !stop_wr && !irq_hit) |=> (!run && count == TOP)); // R4

  AST_IRQ_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && irq_hit && !start_wr) |=> (!run && $stable(count))); // R5

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[30:24] == 7'd0); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start_wr) |=> (!run && $stable(count))); // R10

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start_wr) |=> (count == $past(count) || count == $past(count) + 1'b1)); // R9
endmodule

bind latency_stopwatch sw_checker #(.COUNT_W(COUNT_W), .MAX_COUNT(MAX_COUNT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_wr (start_wr),
  .stop_wr  (stop_wr),
  .irq_hit  (irq_hit),
  .sat_hit  (sat_hit),
  .run      (run),
  .count    (count),
  .rdata    (rdata)
);

// File: tb/sim_latency_stopwatch.sv
module sim_latency_stopwatch;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned T_CLK_HZ   = 1_000_000;
  localparam int unsigned T_TICK_HZ  = 100_000;
  localparam int unsigned T_DIV      = T_CLK_HZ / T_TICK_HZ;
  localparam int unsigned T_MAX      = 40;
  localparam int unsigned T_IRQ_W    = 8;
  localparam logic [6:0]  T_IDX      = 7'h0C;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [7:0]   cmd = 8'd0;
  logic [31:0]  wdata = 32'd0;
  logic [31:0]  rdata;
  logic [T_IRQ_W-1:0] irq_status = '0;
  logic [T_IRQ_W-1:0] irq_enable = '0;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latency_stopwatch #(
    .CLK_HZ(T_CLK_HZ), .TICK_HZ(T_TICK_HZ), .COUNT_W(24),
    .MAX_COUNT(T_MAX), .IRQ_W(T_IRQ_W), .REG_INDEX(T_IDX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .wdata(wdata), .rdata(rdata), .irq_status(irq_status), .irq_enable(irq_enable)
  );

  function automatic logic [31:0] word(input logic r, input int unsigned c);
    return {r, 7'd0, 24'(c)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; issues a one-edge write.
  task automatic wr(input logic [6:0] idx, input logic [31:0] d);
    cmd_valid = 1'b1; cmd = {1'b1, idx}; wdata = d;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; cmd = 8'd0; wdata = 32'd0;
  endtask

  // Combinational read between edges.
  task automatic rd(input logic [6:0] idx, output logic [31:0] v);
    cmd_valid = 1'b1; cmd = {1'b0, idx};
    #1 v = rdata;
    cmd_valid = 1'b0; cmd = 8'd0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(T_IDX, v);
    check("R1 reset value", v, 32'd0);
  endtask

  task automatic t_rate;
    logic [31:0] v;
    wr(T_IDX, 32'h8000_0000);
    rd(T_IDX, v); check("R2 start clears", v, word(1, 0));
    edges(T_DIV - 1);
    rd(T_IDX, v); check("R9 no step before period", v, word(1, 0));
    edges(1);
    rd(T_IDX, v); check("R9 first step", v, word(1, 1));
    edges(T_DIV * 2 + 5);
    rd(T_IDX, v); check("R9 steady rate", v, word(1, 3));
    cmd_valid = 1'b1; cmd = {1'b0, T_IDX + 7'd1}; #1 v = rdata;
    cmd_valid = 1'b0; cmd = 8'd0;
    check("R1 other index reads zero", v, 32'd0);
    wr(T_IDX, 32'h8000_0000);
    rd(T_IDX, v); check("R2 restart while running", v, word(1, 0));
  endtask

  task automatic t_sw_stop;
    logic [31:0] v;
    wr(T_IDX, 32'h8000_0000);
    edges(T_DIV * 3 + 5);
    wr(T_IDX, 32'h7F00_1234);
    rd(T_IDX, v); check("R3 stop keeps count", v, word(0, 3));
    check("R6 reserved bits zero", {25'd0, v[30:24]}, 32'd0);
    edges(50);
    rd(T_IDX, v); check("R3 stays stopped", v, word(0, 3));
    wr(T_IDX + 7'd3, 32'h8000_0000);
    edges(T_DIV * 2);
    rd(T_IDX, v); check("R10 other index write ignored", v, word(0, 3));
  endtask

  task automatic t_saturate;
    logic [31:0] v;
    wr(T_IDX, 32'hFF00_0000);
    edges(T_DIV * T_MAX - 1);
    rd(T_IDX, v); check("R4 just before ceiling", v, word(1, T_MAX - 1));
    edges(1);
    rd(T_IDX, v); check("R4 stops at ceiling", v, word(0, T_MAX));
    edges(T_DIV * 3);
    rd(T_IDX, v); check("R4 holds at ceiling", v, word(0, T_MAX));
  endtask

  task automatic t_irq_freeze;
    logic [31:0] v;
    wr(T_IDX, 32'h8000_0000);
    edges(T_DIV * 2 + 2);
    irq_status = 8'h02; irq_enable = 8'h02;
    edges(1);
    irq_status = '0; irq_enable = '0;
    rd(T_IDX, v); check("R5 irq freezes", v, word(0, 2));
    edges(T_DIV * 5);
    rd(T_IDX, v); check("R5 frozen value held", v, word(0, 2));
  endtask

  task automatic t_masked;
    logic [31:0] v;
    wr(T_IDX, 32'h8000_0000);
    irq_status = 8'hF0; irq_enable = 8'h0F;
    edges(T_DIV * 3);
    irq_status = '0; irq_enable = '0;
    rd(T_IDX, v); check("R7 masked irq ignored", v, word(1, 3));
  endtask

  task automatic t_start_beats_irq;
    logic [31:0] v;
    irq_status = 8'h80; irq_enable = 8'h80;
    wr(T_IDX, 32'h8000_0000);
    irq_status = '0; irq_enable = '0;
    rd(T_IDX, v); check("R8 start wins", v, word(1, 0));
    edges(T_DIV + 5);
    rd(T_IDX, v); check("R8 keeps running", v, word(1, 1));
    wr(T_IDX, 32'h0000_0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rate();
    t_sw_stop();
    t_saturate();
    t_irq_freeze();
    t_masked();
    t_start_beats_irq();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule